// File: doc/BRIEF.md
# Three-Port Crossbar with Per-Slave Priority Arbitration

This block connects three bus masters to three bus slaves over 32-bit address and 32-bit data paths. Each master names one target slave with a slave-select field and raises a request. Every slave port has its own arbiter, so masters that target different slaves are served in the same cycle. When several masters want the same slave, that slave's arbiter hands ownership to one of them. The others stall, with their grant low, until the owner's transaction finishes.

Each master has a static 2-bit priority input and a boost input. While boost is high, the master ranks above every master whose boost is low. Among the requesters with the highest effective priority, the grant rotates. The search starts at the master after the one that slave port last granted. After a grant, the owner's address, write strobe and write data are steered to the slave. The slave's read data and completion strobe are steered back to the owner. Configuration comes only from static input ports.

Top module: `xbar_switch`

## Requirements
- R1: While master i owns slave j, the slave-side address, write strobe and write data of port j equal those of master i. Master i's read data equals slave j's read data. The slave-side buses of an idle slave port and the read data of a master that owns nothing are zero.
- R2: Masters that target different slaves are granted in the same cycle, and each slave port carries its own owner's data.
- R3: Each master's effective priority is the 3-bit value {boost, priority}, and a larger value ranks higher. Among masters requesting an idle slave, one with the highest effective priority is granted.
- R4: An owner keeps the slave while its request (with the same slave select) stays high and the slave's done input is low. The port releases at the clock edge where done is high or the owner's request has dropped. The cycle after the release has no grant, and arbitration runs at the following edge.
- R5: Ties at the highest effective priority are resolved round-robin. The search starts at the master with index one above the last master granted on that slave port, wrapping from 2 to 0.
- R6: A master with boost high beats every requester with boost low, whatever their 2-bit priorities.
- R7: A slave port with no requester grants nothing and holds its slave request low. Its last-granted record is unchanged, and a slave-select value of 3 addresses no slave.
- R8: A request seen at a clock edge on an idle port produces the grant and the slave request in the next cycle. A master's done output equals the done input of the slave it owns, combinationally.
- R9: After reset, no grant or slave request is active, and each port's last-granted record is master 2, so the first tie search starts at master 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mReq | input | 3 | Request per master |
| mSel | input | 6 | 2-bit target slave per master (master i in bits 2i+1:2i) |
| mAddr | input | 96 | 32-bit address per master |
| mWe | input | 3 | Write strobe per master |
| mWdata | input | 96 | 32-bit write data per master |
| mPrio | input | 6 | 2-bit static priority per master |
| mBoost | input | 3 | Temporary priority elevation per master |
| mGnt | output | 3 | Ownership grant per master |
| mRdata | output | 96 | Read data returned to each master |
| mDone | output | 3 | Transaction completion to each master |
| sReq | output | 3 | Transaction active per slave port |
| sAddr | output | 96 | Address per slave port |
| sWe | output | 3 | Write strobe per slave port |
| sWdata | output | 96 | Write data per slave port |
| sRdata | input | 96 | Read data from each slave |
| sDone | input | 3 | Transaction completion from each slave |

## Verification
The main check is a sweep over every combination of request set, boost bits and priorities. All requesters in one case target the same slave, and the target rotates over the three slaves. The bench computes the winner arithmetically and keeps its own last-granted record for each port. Cases with equal priorities separate correct round-robin rotation from a fixed lowest-index choice. Cases with mixed boost bits show that boost outranks the 2-bit priority. Directed patterns cover the rest. A higher-priority late requester shows that an ownership cannot be preempted. A dropped request shows that a release leaves one empty cycle. Three masters on three different slaves show concurrent routing, and an out-of-range select shows that it addresses nothing.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int ID_W = 2;

  typedef struct packed {
    logic            busy;
    logic [ID_W-1:0] owner;
  } route_t;
endpackage

// File: rtl/xbar_port_arb.sv
module xbar_port_arb
  import xbar_pkg::*;
#(
  parameter int NUM_M   = 3,
  parameter int PRIO_W  = 2,
  parameter int SEL_W   = 2,
  parameter int PORT_ID = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_M-1:0]        mReq,
  input  logic [NUM_M*SEL_W-1:0]  mSel,
  input  logic [NUM_M*PRIO_W-1:0] mPrio,
  input  logic [NUM_M-1:0]        mBoost,
  input  logic                    sDone,
  output route_t                  route
);
  localparam int EFF_W = PRIO_W + 1;

  logic [NUM_M-1:0] reqVec;
  logic [EFF_W-1:0] eff [NUM_M];
  logic             busyQ;
  logic [ID_W-1:0]  ownerQ;
  logic [ID_W-1:0]  lastQ;
  logic [ID_W-1:0]  winner;
  logic             found;
  logic [EFF_W-1:0] best;
  logic             ownerStays;

  for (genvar i = 0; i < NUM_M; i++) begin : g_req
    assign reqVec[i] = mReq[i] && (mSel[i*SEL_W +: SEL_W] == SEL_W'(PORT_ID));
    assign eff[i]    = {mBoost[i], mPrio[i*PRIO_W +: PRIO_W]};
  end

  always_comb begin
    found  = 1'b0;
    best   = '0;
    winner = '0;
    for (int k = 0; k < NUM_M; k++) begin
      int idx;
      idx = (int'(lastQ) + 1 + k) % NUM_M;
      if (reqVec[idx] && (!found || eff[idx] > best)) begin
        found  = 1'b1;
        best   = eff[idx];
        winner = ID_W'(idx);
      end
    end
  end

  assign ownerStays = reqVec[ownerQ] && !sDone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ  <= 1'b0;
      ownerQ <= '0;
      lastQ  <= ID_W'(NUM_M - 1);
    end else if (busyQ) begin
      if (!ownerStays) busyQ <= 1'b0;
    end else if (found) begin
      busyQ  <= 1'b1;
      ownerQ <= winner;
      lastQ  <= winner;
    end
  end

  assign route.busy  = busyQ;
  assign route.owner = ownerQ;

  // R4: no change of owner mid-transaction
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busyQ && reqVec[ownerQ] && !sDone |=> busyQ && $stable(ownerQ));
  // R4: completion releases the port
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    busyQ && sDone |=> !busyQ);
  // R7: idle port stays idle and keeps its record
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busyQ && (reqVec == '0) |=> !busyQ && $stable(lastQ));
  // R8: a new grant goes to a master that was requesting
  a_r8_grant_requester: assert property (@(posedge clk) disable iff (!rst_n)
    !busyQ && (reqVec != '0) |=> busyQ && ((($past(reqVec) >> ownerQ) & 1) != 0));
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import xbar_pkg::*;
#(
  parameter int NUM_M = 3,
  parameter int NUM_S = 3,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  route_t              route [NUM_S],
  input  logic [NUM_M*AW-1:0] mAddr,
  input  logic [NUM_M-1:0]    mWe,
  input  logic [NUM_M*DW-1:0] mWdata,
  output logic [NUM_M-1:0]    mGnt,
  output logic [NUM_M*DW-1:0] mRdata,
  output logic [NUM_M-1:0]    mDone,
  output logic [NUM_S-1:0]    sReq,
  output logic [NUM_S*AW-1:0] sAddr,
  output logic [NUM_S-1:0]    sWe,
  output logic [NUM_S*DW-1:0] sWdata,
  input  logic [NUM_S*DW-1:0] sRdata,
  input  logic [NUM_S-1:0]    sDone
);
  for (genvar j = 0; j < NUM_S; j++) begin : g_slv
    always_comb begin
      sReq[j]             = route[j].busy;
      sAddr[j*AW +: AW]   = '0;
      sWe[j]              = 1'b0;
      sWdata[j*DW +: DW]  = '0;
      if (route[j].busy) begin
        sAddr[j*AW +: AW]  = mAddr[route[j].owner*AW +: AW];
        sWe[j]             = mWe[route[j].owner];
        sWdata[j*DW +: DW] = mWdata[route[j].owner*DW +: DW];
      end
    end
  end

  for (genvar i = 0; i < NUM_M; i++) begin : g_mst
    logic [NUM_S-1:0] ownVec;

    always_comb begin
      mGnt[i]            = 1'b0;
      mDone[i]           = 1'b0;
      mRdata[i*DW +: DW] = '0;
      for (int j = 0; j < NUM_S; j++) begin
        ownVec[j] = route[j].busy && (route[j].owner == ID_W'(i));
        if (ownVec[j]) begin
          mGnt[i]            = 1'b1;
          mDone[i]           = sDone[j];
          mRdata[i*DW +: DW] = sRdata[j*DW +: DW];
        end
      end
    end

    // R2: a master never owns two slave ports at once
    a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ownVec));
  end
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
  import xbar_pkg::*;
#(
  parameter int NUM_M  = 3,
  parameter int NUM_S  = 3,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int PRIO_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_M-1:0]        mReq,
  input  logic [NUM_M*2-1:0]      mSel,
  input  logic [NUM_M*AW-1:0]     mAddr,
  input  logic [NUM_M-1:0]        mWe,
  input  logic [NUM_M*DW-1:0]     mWdata,
  input  logic [NUM_M*PRIO_W-1:0] mPrio,
  input  logic [NUM_M-1:0]        mBoost,
  output logic [NUM_M-1:0]        mGnt,
  output logic [NUM_M*DW-1:0]     mRdata,
  output logic [NUM_M-1:0]        mDone,
  output logic [NUM_S-1:0]        sReq,
  output logic [NUM_S*AW-1:0]     sAddr,
  output logic [NUM_S-1:0]        sWe,
  output logic [NUM_S*DW-1:0]     sWdata,
  input  logic [NUM_S*DW-1:0]     sRdata,
  input  logic [NUM_S-1:0]        sDone
);
  route_t route [NUM_S];

  initial begin
    assert (NUM_M <= (1 << ID_W) && NUM_S <= 4)
      else $error("port counts exceed id or select width");
  end

  for (genvar j = 0; j < NUM_S; j++) begin : g_arb
    xbar_port_arb #(
      .NUM_M(NUM_M), .PRIO_W(PRIO_W), .SEL_W(2), .PORT_ID(j)
    ) u_arb (
      .clk(clk), .rst_n(rst_n), .mReq(mReq), .mSel(mSel),
      .mPrio(mPrio), .mBoost(mBoost), .sDone(sDone[j]), .route(route[j])
    );
  end

  xbar_datapath #(.NUM_M(NUM_M), .NUM_S(NUM_S), .AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .route(route),
    .mAddr(mAddr), .mWe(mWe), .mWdata(mWdata),
    .mGnt(mGnt), .mRdata(mRdata), .mDone(mDone),
    .sReq(sReq), .sAddr(sAddr), .sWe(sWe), .sWdata(sWdata),
    .sRdata(sRdata), .sDone(sDone)
  );
endmodule

// File: tb/tb_xbar_switch.sv
module tb_xbar_switch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mReq = '0, mWe = '0, mBoost = '0, mGnt, mDone;
  logic [5:0]  mSel = '0, mPrio = '0;
  logic [95:0] mAddr = '0, mWdata = '0, mRdata;
  logic [2:0]  sReq, sWe, sDone = '0;
  logic [95:0] sAddr, sWdata, sRdata;
  int compared = 0, mismatched = 0;
  bit finished = 0;
  int lastG [3];

  always #4 clk = ~clk;

  xbar_switch dut (
    .clk(clk), .rst_n(rst_n), .mReq(mReq), .mSel(mSel), .mAddr(mAddr),
    .mWe(mWe), .mWdata(mWdata), .mPrio(mPrio), .mBoost(mBoost),
    .mGnt(mGnt), .mRdata(mRdata), .mDone(mDone), .sReq(sReq),
    .sAddr(sAddr), .sWe(sWe), .sWdata(sWdata), .sRdata(sRdata), .sDone(sDone)
  );

  for (genvar j = 0; j < 3; j++) begin : g_srd
    assign sRdata[j*32 +: 32] = 32'h5000_0000 + 32'(j) * 32'h11;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idleAll();
    mReq = '0; sDone = '0; mBoost = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 3; j++) lastG[j] = 2;
    for (int i = 0; i < 3; i++) begin
      mAddr[i*32 +: 32]  = 32'hA000_0000 + 32'(i) * 32'h100;
      mWdata[i*32 +: 32] = 32'hD000_0000 + 32'(i);
    end
    mWe = 3'b101;
    repeat (3) @(negedge clk);
    chk(mGnt == 3'b000 && sReq == 3'b000, "R9 reset grants", {26'd0, mGnt, sReq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: request set x boost x priority, one target slave per case
    for (int code = 0; code < 4096; code++) begin
      logic [2:0] rq, bst;
      logic [5:0] pr;
      int tgt, win, bestV;
      bit found;
      rq  = code[2:0];
      bst = code[5:3];
      pr  = code[11:6];
      tgt = code % 3;
      found = 0; bestV = 0; win = 0;
      for (int k = 0; k < 3; k++) begin
        int idx, ev;
        idx = (lastG[tgt] + 1 + k) % 3;
        ev  = int'(bst[idx]) * 4 + int'(pr[idx*2 +: 2]);
        if (rq[idx] && (!found || ev > bestV)) begin
          found = 1; bestV = ev; win = idx;
        end
      end
      mReq = rq; mBoost = bst; mPrio = pr;
      mSel = {2'(tgt), 2'(tgt), 2'(tgt)};
      @(negedge clk);
      if (rq == 3'b000) begin
        chk(mGnt == 3'b000 && sReq == 3'b000, "R7 idle port", {29'd0, mGnt}, 32'd0);
        continue;
      end
      chk(mGnt == 3'(1 << win), "R3 R5 R6 winner", {29'd0, mGnt}, 32'(1 << win));
      chk(sReq == 3'(1 << tgt), "R8 slave request timing", {29'd0, sReq}, 32'(1 << tgt));
      chk(sAddr[tgt*32 +: 32] == mAddr[win*32 +: 32], "R1 address route",
          sAddr[tgt*32 +: 32], mAddr[win*32 +: 32]);
      chk(mRdata[win*32 +: 32] == sRdata[tgt*32 +: 32], "R1 read data route",
          mRdata[win*32 +: 32], sRdata[tgt*32 +: 32]);
      sDone[tgt] = 1'b1;
      #1;
      chk(mDone == 3'(1 << win), "R8 done steering", {29'd0, mDone}, 32'(1 << win));
      @(negedge clk);
      chk(mGnt == 3'b000, "R4 gap after release", {29'd0, mGnt}, 32'd0);
      lastG[tgt] = win;
      idleAll();
    end

    // R4: late higher-priority requester cannot preempt the owner
    @(negedge clk);
    mSel = {2'd1, 2'd1, 2'd1}; mPrio = {2'd3, 2'd3, 2'd0}; mReq = 3'b001;
    @(negedge clk);
    chk(mGnt == 3'b001, "R4 low-priority owner", {29'd0, mGnt}, 32'd1);
    mReq = 3'b101;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(mGnt == 3'b001, "R4 hold against higher priority", {29'd0, mGnt}, 32'd1);
    end
    chk(sWe == 3'b010 && sWdata[63:32] == mWdata[31:0], "R1 write route",
        sWdata[63:32], mWdata[31:0]);
    sDone[1] = 1'b1;
    @(negedge clk);
    sDone[1] = 1'b0;
    chk(mGnt == 3'b000, "R4 empty cycle after done", {29'd0, mGnt}, 32'd0);
    @(negedge clk);
    chk(mGnt == 3'b100, "R3 rearbitration after release", {29'd0, mGnt}, 32'd4);

    // R4: owner dropping its request releases the port
    mReq = 3'b001;
    @(negedge clk);
    chk(mGnt == 3'b000, "R4 release on request drop", {29'd0, mGnt}, 32'd0);
    @(negedge clk);
    chk(mGnt == 3'b001, "R4 next requester after drop", {29'd0, mGnt}, 32'd1);
    idleAll();
    @(negedge clk);
    @(negedge clk);

    // R2: three masters on three slaves at once
    mSel = {2'd2, 2'd1, 2'd0}; mReq = 3'b111;
    @(negedge clk);
    chk(mGnt == 3'b111 && sReq == 3'b111, "R2 concurrent grants", {26'd0, mGnt, sReq}, 32'h3f);
    for (int j = 0; j < 3; j++) begin
      chk(sAddr[j*32 +: 32] == mAddr[j*32 +: 32], "R2 concurrent address",
          sAddr[j*32 +: 32], mAddr[j*32 +: 32]);
      chk(mRdata[j*32 +: 32] == sRdata[j*32 +: 32], "R2 concurrent read data",
          mRdata[j*32 +: 32], sRdata[j*32 +: 32]);
    end
    chk(sWe == mWe, "R2 concurrent write strobe", {29'd0, sWe}, {29'd0, mWe});
    sDone = 3'b111;
    @(negedge clk);
    idleAll();
    @(negedge clk);

    // R7: select value 3 addresses no slave
    mSel = {2'd3, 2'd3, 2'd3}; mReq = 3'b111;
    @(negedge clk);
    @(negedge clk);
    chk(mGnt == 3'b000 && sReq == 3'b000 && sAddr == '0, "R7 out-of-range select",
        {26'd0, mGnt, sReq}, 32'd0);
    idleAll();
    @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule